// File: doc/BRIEF.md
# Ramping-Delay Pulse Pair Generator

This block produces two related pulse outputs from a single tick clock. The first output is a square wave that repeats for as long as the block runs. Each period is a programmed number of high ticks followed by a programmed number of low ticks. The second output gives one pulse for every group of N pulses on the first output. The pulse is measured from the rising edge that closes the group.

The offset of the second output from its group boundary is zero on the first group. It grows by a fixed number of ticks on each later group. Once the offset would pass a programmed ceiling, the pulse that was just issued becomes the last one. When that pulse ends, the block raises `done` and drives both outputs low.

A host sets the configuration inputs and then pulses `start`. The configuration must stay stable while the block runs. The block can be started again once it reports `done`.

Top module: `ramp_pulse_gen`

## Requirements
- R1: After `start` is accepted on clock edge S, `pulse_a` is high for `cfg_high` ticks starting at edge S, then low for `cfg_low` ticks, and this pattern repeats (both counts at least 1).
- R2: The rising edges of `pulse_a` are numbered from 1, and the pulse starting at S is number 1. Every rising edge whose number is a multiple of `cfg_group` is a group boundary, and each boundary asks for exactly one `pulse_b` pulse.
- R3: The k-th requested `pulse_b` pulse (k from 0) uses an offset of k·`cfg_step` ticks. The first pulse rises on the same edge as its boundary.
- R4: Each `pulse_b` pulse stays high for exactly `cfg_width` ticks (at least 1).
- R5: A request is never dropped. Request k rises at max(boundary_k, previous_rise + `cfg_width` + 1) + k·`cfg_step`, so a request that comes while a pulse is pending or active waits for that pulse.
- R6: The last pulse is the one whose offset is the largest multiple of `cfg_step` that does not exceed `cfg_max`. On the edge where that pulse falls, `done` goes to 1 and `pulse_a` goes to 0. Both outputs then stay low and `done` stays high until the next accepted `start`.
- R7: `start` is ignored while a run is in progress. The waveforms continue exactly as scheduled.
- R8: A `start` after `done` begins a fresh run. The offset returns to zero, the group count restarts, and `done` drops on the accepted edge.
- R9: A synchronous reset leaves `pulse_a`, `pulse_b` and `done` all low, and the block idle.
- R10: With 5000 high and 5000 low ticks, `pulse_a` has a period of 10000 ticks, which is 2 kHz from a 20 MHz tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock shared by both outputs |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle or done |
| cfg_high | input | CNT_W | High ticks of each pulse_a period |
| cfg_low | input | CNT_W | Low ticks of each pulse_a period |
| cfg_group | input | GRP_W | Number of pulse_a pulses per group (default use: 5) |
| cfg_step | input | CNT_W | Offset increment in ticks per group |
| cfg_max | input | CNT_W | Largest allowed offset in ticks |
| cfg_width | input | CNT_W | pulse_b width in ticks (default use: 1) |
| pulse_a | output | 1 | Continuous pulse train |
| pulse_b | output | 1 | Delayed single pulse per group |
| done | output | 1 | Run finished, outputs held low |

## Verification
The bench builds the block with its default parameters: 16-bit tick counters, 8-bit group count and a 4-bit pending-request counter. The 16-bit counters are wide enough for the 5000-tick phases of the 2 kHz default train, which the bench checks across several periods. The 4-bit pending counter leaves room for a configuration whose growing offsets overrun later group boundaries, so queued requests and their one-tick relaunch gap are covered. Short runs with small tick counts cover a ceiling that is a multiple of the step, one that is not, a group size of one, and restarts from `done`.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  typedef enum logic [1:0] {
    B_IDLE  = 2'd0,
    B_WAIT  = 2'd1,
    B_PULSE = 2'd2
  } bstate_e;

  // True when the offset after this launch would pass the ceiling.
  function automatic logic ramp_last(input logic [31:0] cur,
                                     input logic [31:0] step,
                                     input logic [31:0] lim);
    return (cur + step) > lim;
  endfunction

  // Next value of a wrapping group counter.
  function automatic logic [31:0] grp_next(input logic [31:0] cnt,
                                           input logic        at_bnd);
    return at_bnd ? 32'd0 : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/rpg_train.sv
module rpg_train #(
  parameter int CNT_W = 16,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             en,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [GRP_W-1:0] cfg_group,
  output logic             a_q,
  output logic             rise,
  output logic             bnd
);
  import rpg_pkg::*;

  logic [CNT_W-1:0] acnt;
  logic [GRP_W-1:0] gcnt;
  logic [GRP_W-1:0] gcnt_eff;
  logic [GRP_W-1:0] gcnt_nxt;
  logic             phase_end;

  assign phase_end = (acnt == '0);
  assign rise      = go | (en & ~a_q & phase_end);
  assign gcnt_eff  = go ? '0 : gcnt;
  assign bnd       = rise & (gcnt_eff == cfg_group - GRP_W'(1));
  assign gcnt_nxt  = GRP_W'(grp_next(32'(gcnt_eff), bnd));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= 1'b0;
      acnt <= '0;
      gcnt <= '0;
    end else if (go) begin
      a_q  <= 1'b1;
      acnt <= cfg_high - CNT_W'(1);
      gcnt <= gcnt_nxt;
    end else if (!en) begin
      a_q  <= 1'b0;
    end else if (phase_end) begin
      a_q  <= ~a_q;
      acnt <= a_q ? cfg_low - CNT_W'(1) : cfg_high - CNT_W'(1);
      if (rise) gcnt <= gcnt_nxt;
    end else begin
      acnt <= acnt - CNT_W'(1);
    end
  end

  AST_RISE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise |=> a_q); // R1
  AST_HIGH_PHASE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (en && !go && a_q && phase_end) |=> !a_q); // R1
  AST_GROUP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_group != '0) |-> (gcnt < cfg_group)); // R2

endmodule

// File: rtl/rpg_bsched.sv
module rpg_bsched #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bnd,
  input  logic [CNT_W-1:0] cfg_step,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             b_q,
  output logic             fin_last
);
  import rpg_pkg::*;

  bstate_e           st_q, st_e;
  logic [CNT_W-1:0]  dcnt, bcnt, acc_q, acc_e;
  logic [PEND_W-1:0] pend_q, pend_e;
  logic              closed_q, closed_e, last_q, last_e;
  logic              launch, fin, pend_inc, pend_dec, is_last;

  // A start clears the run state in the same cycle it may see a boundary.
  assign st_e     = clr ? B_IDLE : st_q;
  assign acc_e    = clr ? '0 : acc_q;
  assign pend_e   = clr ? '0 : pend_q;
  assign closed_e = clr ? 1'b0 : closed_q;
  assign last_e   = clr ? 1'b0 : last_q;

  assign launch   = (st_e == B_IDLE) && !closed_e && (pend_e != '0 || bnd);
  assign fin      = (st_e == B_PULSE) && (bcnt == '0);
  assign fin_last = fin && last_e;
  assign pend_dec = launch && (pend_e != '0);
  assign pend_inc = bnd && !closed_e && !(launch && pend_e == '0);
  assign is_last  = ramp_last(32'(acc_e), 32'(cfg_step), 32'(cfg_max));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= B_IDLE;
      b_q      <= 1'b0;
      dcnt     <= '0;
      bcnt     <= '0;
      acc_q    <= '0;
      pend_q   <= '0;
      closed_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      pend_q   <= pend_e + PEND_W'(pend_inc) - PEND_W'(pend_dec);
      acc_q    <= acc_e;
      closed_q <= closed_e;
      last_q   <= last_e;
      st_q     <= st_e;
      if (launch) begin
        acc_q    <= acc_e + cfg_step;
        closed_q <= is_last;
        last_q   <= is_last;
        if (acc_e == '0) begin
          st_q <= B_PULSE;
          b_q  <= 1'b1;
          bcnt <= cfg_width - CNT_W'(1);
        end else begin
          st_q <= B_WAIT;
          dcnt <= acc_e - CNT_W'(1);
        end
      end else if (st_e == B_WAIT) begin
        if (dcnt == '0) begin
          st_q <= B_PULSE;
          b_q  <= 1'b1;
          bcnt <= cfg_width - CNT_W'(1);
        end else begin
          dcnt <= dcnt - CNT_W'(1);
        end
      end else if (st_e == B_PULSE) begin
        if (fin) begin
          st_q <= B_IDLE;
          b_q  <= 1'b0;
        end else begin
          bcnt <= bcnt - CNT_W'(1);
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(pend_inc && !pend_dec && (&pend_e))); // R5
  AST_OFFSET_CAP: assert property (@(posedge clk) disable iff (rst)
    launch |-> (acc_e <= cfg_max)); // R6
  AST_ZERO_OFFSET_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (launch && acc_e == '0) |=> b_q); // R3
  AST_FIN_DROPS_B: assert property (@(posedge clk) disable iff (rst)
    fin |=> !b_q); // R4

endmodule

// File: rtl/ramp_pulse_gen.sv
module ramp_pulse_gen #(
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [GRP_W-1:0] cfg_group,
  input  logic [CNT_W-1:0] cfg_step,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             pulse_a,
  output logic             pulse_b,
  output logic             done
);

  logic run_q;
  logic go;
  logic fin_last;
  logic a_rise;
  logic grp_bnd;

  assign go = start && !run_q;

  rpg_train #(.CNT_W(CNT_W), .GRP_W(GRP_W)) train_i (
    .clk(clk), .rst(rst), .go(go), .en(run_q && !fin_last),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_group(cfg_group),
    .a_q(pulse_a), .rise(a_rise), .bnd(grp_bnd)
  );

  rpg_bsched #(.CNT_W(CNT_W), .PEND_W(PEND_W)) bsched_i (
    .clk(clk), .rst(rst), .clr(go), .bnd(grp_bnd),
    .cfg_step(cfg_step), .cfg_max(cfg_max), .cfg_width(cfg_width),
    .b_q(pulse_b), .fin_last(fin_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      done  <= 1'b0;
    end else if (go) begin
      run_q <= 1'b1;
      done  <= 1'b0;
    end else if (fin_last) begin
      run_q <= 1'b0;
      done  <= 1'b1;
    end
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pulse_a && !pulse_b)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (run_q && start && !fin_last) |=> run_q); // R7
  AST_B_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    pulse_b |-> run_q); // R6
  AST_RISE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    a_rise |-> (run_q || start)); // R7

endmodule

// File: tb/ramp_pulse_gen_tb.sv
`timescale 1ns/1ps
module ramp_pulse_gen_tb_top;
  localparam int CW = 16;
  localparam int GW = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] cfg_high = '0, cfg_low = '0, cfg_step = '0, cfg_max = '0, cfg_width = '0;
  logic [GW-1:0] cfg_group = '0;
  logic pulse_a, pulse_b, done;

  always #2.5 clk = ~clk;

  ramp_pulse_gen dut_i (
    .clk(clk), .rst(rst), .start(start),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_group(cfg_group),
    .cfg_step(cfg_step), .cfg_max(cfg_max), .cfg_width(cfg_width),
    .pulse_a(pulse_a), .pulse_b(pulse_b), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int qb[$];
  int cur_w = 1;
  int b_rise_at = 0;
  logic b_prev = 1'b0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  int exp_e;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Scoreboard monitor: every rising edge of pulse_b pops one expected cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      if (pulse_b && !b_prev) begin
        if (qb.size() == 0) begin
          check(1'b0, "R5 unexpected pulse_b rise", cyc, -1);
        end else begin
          exp_e = qb.pop_front();
          check(cyc == exp_e, "R3 pulse_b rise cycle", cyc, exp_e);
        end
        b_rise_at = cyc;
      end
      if (!pulse_b && b_prev)
        check(cyc - b_rise_at == cur_w, "R4 pulse_b width", cyc - b_rise_at, cur_w);
    end
    b_prev = pulse_b;
  end

  always @(negedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      check(1'b0, "watchdog", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic wait_to(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic pulse_start(output int s);
    @(negedge clk);
    start = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Driver: configures, starts, pushes the expected pulse_b schedule, checks the end.
  task automatic run_case(input int h, input int l, input int n, input int step,
                          input int mx, input int w, input bit poke);
    int s, prev, acc, g, e, lch, done_at;
    cfg_high = CW'(h); cfg_low = CW'(l); cfg_group = GW'(n);
    cfg_step = CW'(step); cfg_max = CW'(mx); cfg_width = CW'(w);
    cur_w = w;
    pulse_start(s);
    prev = -100000; acc = 0; g = 0;
    forever begin
      e = s + (g * n + n - 1) * (h + l);
      lch = (e > prev + w + 1) ? e : prev + w + 1;
      qb.push_back(lch + acc);
      prev = lch + acc;
      if (acc + step > mx) break;
      acc += step;
      g++;
    end
    done_at = prev + w;
    check(done == 1'b0, "R8 done cleared after start", done, 0);
    wait_to(s + h - 1);
    check(pulse_a == 1'b1, "R1 high phase end", pulse_a, 1);
    wait_to(s + h);
    check(pulse_a == 1'b0, "R1 low phase begins", pulse_a, 0);
    wait_to(s + h + l);
    check(pulse_a == 1'b1, "R1 next period begins", pulse_a, 1);
    if (poke) begin
      wait_to(s + h + l + 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7 start ignored while running", done, 0);
    end
    wait_to(done_at - 1);
    check(done == 1'b0 && pulse_b == 1'b1, "R6 last pulse still high", {done, pulse_b}, 1);
    wait_to(done_at);
    check(done == 1'b1, "R6 done on last fall", done, 1);
    check(pulse_a == 1'b0 && pulse_b == 1'b0, "R6 outputs low at done", {pulse_a, pulse_b}, 0);
    wait_to(done_at + 2 * (h + l) + 5);
    check(pulse_a == 1'b0 && done == 1'b1, "R6 held quiet after done", {pulse_a, done}, 1);
    check(qb.size() == 0, "R2 every group pulse seen", qb.size(), 0);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    check(pulse_a == 1'b0 && pulse_b == 1'b0 && done == 1'b0, "R9 reset state",
          {pulse_a, pulse_b, done}, 0);
    rst = 1'b0;

    // R10 default train: 5000/5000 ticks, group of 5
    cfg_high = CW'(5000); cfg_low = CW'(5000); cfg_group = GW'(5);
    cfg_step = CW'(1000); cfg_max = CW'(10000); cfg_width = CW'(1);
    pulse_start(s);
    wait_to(s + 4999);
    check(pulse_a == 1'b1, "R10 high for 5000 ticks", pulse_a, 1);
    wait_to(s + 5000);
    check(pulse_a == 1'b0, "R10 low after 5000 ticks", pulse_a, 0);
    wait_to(s + 9999);
    check(pulse_a == 1'b0, "R10 still low at tick 9999", pulse_a, 0);
    wait_to(s + 10000);
    check(pulse_a == 1'b1, "R10 period 10000 ticks", pulse_a, 1);
    wait_to(s + 20000);
    check(pulse_a == 1'b1, "R10 second period", pulse_a, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pulse_a == 1'b0 && pulse_b == 1'b0 && done == 1'b0, "R9 reset mid-run",
          {pulse_a, pulse_b, done}, 0);
    rst = 1'b0;
    b_prev = 1'b0;
    mon_on = 1'b1;

    // R3 group of 5, eleven ramping pulses, a stray start mid-run (R7)
    run_case(2, 3, 5, 4, 40, 1, 1'b1);
    // R5 offsets overrun later boundaries; wide pulses queue requests
    run_case(1, 1, 2, 3, 9, 2, 1'b0);
    // R8 restart from done; group of one; ceiling not a multiple of the step
    run_case(3, 3, 1, 5, 12, 1, 1'b0);

    summary();
  end

endmodule